// File: doc/BRIEF.md
# Predicated Execution and If-Then Sequencer

This block sits at the retire end of a processor pipeline and gives, for the instruction being retired, a single yes/no: execute it, or squash it. The answer comes from a 4-bit condition code tested against four stored condition flags: negative, zero, carry and overflow. An instruction that is squashed still takes its retire slot. The pipeline is not flushed and nothing is refetched.

The block also holds an if-then sequencer for the compact instruction state. In that state only branches carry a condition of their own. An if-then instruction therefore loads a base condition and a short then/else pattern. The sequencer hands that condition, or its inverse, to each of the next one to four retired instructions. After the last one it returns to idle. A flush or exception clears the sequencer at once.

The flags change only when a retiring, executing instruction asks for an update.

Top module: `pred_it_unit`

## Requirements
- R1: A condition code's low bit inverts the test chosen by its upper three bits. The upper-bit values 0 to 6 select, in order: Z; C; N; V; C and not Z; N equal to V; not Z and N equal to V. Codes 0 to 14 are therefore EQ, NE, CS, CC, MI, PL, VS, VC, HI, LS, GE, LT, GT, LE and AL.
- R2: Codes 14 and 15 always execute, whatever the flags.
- R3: Outside an if-then run, an instruction with `cond_valid_i` low executes unconditionally. With `cond_valid_i` high, it is tested against `cond_i`.
- R4: `flags_o` is {N,Z,C,V} on bits 3..0, the order of status word bits 31..28. It loads `flag_data_i` on the edge after a cycle in which `retire_i`, `flag_we_i` and `exec_o` are all high. At any other time it holds its value. A squashed instruction never changes the flags.
- R5: `exec_o` is combinational and is valid in the same cycle as `retire_i`. A retire advances the if-then run whether the instruction executes or is squashed.
- R6: `it_start_i` loads `it_mask_i`. The position of the lowest set bit gives the run length: bit 3 gives 1 instruction, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. A mask of 0000 is ignored.
- R7: The first instruction of a run uses the base condition. Instruction k, for k = 2..4, uses mask bit (5-k): 0 selects the base condition, 1 selects its inverse. The inverse is the base code with bit 0 flipped.
- R8: During a run, `cond_valid_i` and `cond_i` have no effect on `exec_o`.
- R9: `flush_i` clears the run on the next edge and overrides `it_start_i` in the same cycle. When `it_start_i` and `retire_i` arrive together, the new run is loaded unshortened.
- R10: `it_active_o` is high exactly while a run has instructions left to cover.
- R11: After reset the flags read 0000 and no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Pipeline flush or exception; ends any run |
| it_start_i | input | 1 | An if-then instruction is retiring |
| it_base_i | input | 4 | Base condition for the run |
| it_mask_i | input | 4 | Then/else pattern with terminating one |
| retire_i | input | 1 | An instruction is retiring this cycle |
| cond_valid_i | input | 1 | Retiring instruction carries its own condition |
| cond_i | input | 4 | That instruction's condition code |
| flag_we_i | input | 1 | Instruction requests a flag update |
| flag_data_i | input | 4 | New flags {N,Z,C,V} |
| exec_o | output | 1 | 1 = execute, 0 = squash |
| flags_o | output | 4 | Current flags {N,Z,C,V} |
| it_active_o | output | 1 | An if-then run is in progress |

## Verification
The hardest cases to reach are the later slots of long runs. There the condition in force is the inverse of the base, chosen by a mask bit two or three positions down. It also has to be tested against flags that were loaded earlier and that make it fail. The stimulus first loads a known flag value through an unconditional update, then starts a run. It then retires every slot while presenting unrelated conditions on the direct path. This is swept over every non-zero mask and every base code, so that every slot meets both polarities and many flag values. Flush and start collisions, and flag writes by squashed instructions, are set up as separate directed sequences.

// File: rtl/pred_pkg.sv
package pred_pkg;

    localparam int CODE_W = 4;
    localparam int FLAG_W = 4;

    typedef enum logic [CODE_W-1:0] {
        CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
        CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
        CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
        CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    function automatic logic cond_holds(cond_e code, flags_t f);
        logic r;
        case (code)
            CC_EQ: r = f.z;
            CC_NE: r = !f.z;
            CC_CS: r = f.c;
            CC_CC: r = !f.c;
            CC_MI: r = f.n;
            CC_PL: r = !f.n;
            CC_VS: r = f.v;
            CC_VC: r = !f.v;
            CC_HI: r = f.c && !f.z;
            CC_LS: r = !f.c || f.z;
            CC_GE: r = (f.n == f.v);
            CC_LT: r = (f.n != f.v);
            CC_GT: r = !f.z && (f.n == f.v);
            CC_LE: r = f.z || (f.n != f.v);
            default: r = 1'b1;
        endcase
        return r;
    endfunction

    function automatic cond_e cond_invert(cond_e code);
        return cond_e'(code ^ 4'h1);
    endfunction

endpackage

// File: rtl/pred_flag_reg.sv
module pred_flag_reg
    import pred_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   wr_en,
    input  flags_t wr_data,
    output flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else if (wr_en) begin
            flags <= wr_data;
        end
    end
endmodule

// File: rtl/pred_it_seq.sv
module pred_it_seq
    import pred_pkg::*;
#(
    parameter int MAX_RUN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic               start,
    input  cond_e              start_base,
    input  logic [MAX_RUN-1:0] start_mask,
    input  logic               retire,
    output logic               active,
    output cond_e              slot_cond
);
    localparam int SHAPE_W = MAX_RUN + 1;

    cond_e              base_q;
    logic [SHAPE_W-1:0] shape_q;
    logic               start_ok;

    assign start_ok = start && (|start_mask);
    assign active   = |shape_q[MAX_RUN-1:0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            shape_q <= '0;
            base_q  <= CC_AL;
        end else if (start_ok) begin
            shape_q <= {1'b0, start_mask};
            base_q  <= start_base;
        end else if (retire && active) begin
            shape_q <= {shape_q[MAX_RUN-1:0], 1'b0};
        end
    end

    always_comb begin
        if (shape_q[MAX_RUN]) begin
            slot_cond = cond_invert(base_q);
        end else begin
            slot_cond = base_q;
        end
    end
endmodule

// File: rtl/pred_cond_sel.sv
module pred_cond_sel
    import pred_pkg::*;
(
    input  logic   it_active,
    input  cond_e  it_cond,
    input  logic   has_cond,
    input  cond_e  own_cond,
    input  flags_t flags,
    output logic   exec
);
    cond_e pick;

    always_comb begin
        if (it_active) begin
            pick = it_cond;
        end else if (has_cond) begin
            pick = own_cond;
        end else begin
            pick = CC_AL;
        end
        exec = cond_holds(pick, flags);
    end
endmodule

// File: rtl/pred_it_unit.sv
module pred_it_unit
    import pred_pkg::*;
#(
    parameter int MAX_RUN = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush_i,
    input  logic               it_start_i,
    input  logic [3:0]         it_base_i,
    input  logic [MAX_RUN-1:0] it_mask_i,
    input  logic               retire_i,
    input  logic               cond_valid_i,
    input  logic [3:0]         cond_i,
    input  logic               flag_we_i,
    input  logic [3:0]         flag_data_i,
    output logic               exec_o,
    output logic [3:0]         flags_o,
    output logic               it_active_o
);
    flags_t cur_flags;
    cond_e  seq_cond;
    logic   seq_active;
    logic   exec_w;
    logic   flag_wr;

    pred_it_seq #(.MAX_RUN(MAX_RUN)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_i),
        .start      (it_start_i),
        .start_base (cond_e'(it_base_i)),
        .start_mask (it_mask_i),
        .retire     (retire_i),
        .active     (seq_active),
        .slot_cond  (seq_cond)
    );

    pred_cond_sel u_sel (
        .it_active (seq_active),
        .it_cond   (seq_cond),
        .has_cond  (cond_valid_i),
        .own_cond  (cond_e'(cond_i)),
        .flags     (cur_flags),
        .exec      (exec_w)
    );

    assign flag_wr = retire_i && flag_we_i && exec_w;

    pred_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (flag_wr),
        .wr_data (flags_t'(flag_data_i)),
        .flags   (cur_flags)
    );

    assign exec_o      = exec_w;
    assign flags_o     = cur_flags;
    assign it_active_o = seq_active;
endmodule

// File: rtl/pred_it_chk.sv
module pred_it_chk #(
    parameter int MAX_RUN = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               flush_i,
    input logic               it_start_i,
    input logic [MAX_RUN-1:0] it_mask_i,
    input logic               retire_i,
    input logic               cond_valid_i,
    input logic [3:0]         cond_i,
    input logic               flag_we_i,
    input logic [3:0]         flag_data_i,
    input logic               exec_o,
    input logic [3:0]         flags_o,
    input logic               it_active_o
);
    p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !(retire_i && flag_we_i && exec_o) |=> $stable(flags_o));

    p_flags_load_r4: assert property (@(posedge clk) disable iff (rst)
        (retire_i && flag_we_i && exec_o) |=> flags_o == $past(flag_data_i));

    p_always_code_r2: assert property (@(posedge clk) disable iff (rst)
        (!it_active_o && cond_valid_i && cond_i[3:1] == 3'b111) |-> exec_o);

    p_no_field_exec_r3: assert property (@(posedge clk) disable iff (rst)
        (!it_active_o && !cond_valid_i) |-> exec_o);

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> !it_active_o);

    p_start_arms_r6: assert property (@(posedge clk) disable iff (rst)
        (it_start_i && !flush_i && (|it_mask_i)) |=> it_active_o);

    p_idle_stays_r10: assert property (@(posedge clk) disable iff (rst)
        (!it_active_o && !it_start_i) |=> !it_active_o);
endmodule

bind pred_it_unit pred_it_chk #(.MAX_RUN(MAX_RUN)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .it_start_i   (it_start_i),
    .it_mask_i    (it_mask_i),
    .retire_i     (retire_i),
    .cond_valid_i (cond_valid_i),
    .cond_i       (cond_i),
    .flag_we_i    (flag_we_i),
    .flag_data_i  (flag_data_i),
    .exec_o       (exec_o),
    .flags_o      (flags_o),
    .it_active_o  (it_active_o)
);

// File: tb/tb_pred_it_unit.sv
module tb_pred_it_unit;
    logic       clk = 1'b0;
    logic       rst;
    logic       flush_i, it_start_i, retire_i, cond_valid_i, flag_we_i;
    logic [3:0] it_base_i, it_mask_i, cond_i, flag_data_i;
    logic       exec_o, it_active_o;
    logic [3:0] flags_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pred_it_unit dut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .it_start_i(it_start_i),
        .it_base_i(it_base_i), .it_mask_i(it_mask_i), .retire_i(retire_i),
        .cond_valid_i(cond_valid_i), .cond_i(cond_i), .flag_we_i(flag_we_i),
        .flag_data_i(flag_data_i), .exec_o(exec_o), .flags_o(flags_o),
        .it_active_o(it_active_o)
    );

    function automatic logic ref_pass(logic [3:0] code, logic [3:0] f);
        logic n, z, c, v, t;
        {n, z, c, v} = f;
        case (code[3:1])
            3'd0: t = z;
            3'd1: t = c;
            3'd2: t = n;
            3'd3: t = v;
            3'd4: t = c & ~z;
            3'd5: t = ~(n ^ v);
            3'd6: t = ~z & ~(n ^ v);
            default: return 1'b1;
        endcase
        return t ^ code[0];
    endfunction

    function automatic int run_len(logic [3:0] m);
        for (int b = 0; b < 4; b++) if (m[b]) return 4 - b;
        return 0;
    endfunction

    task automatic chk(logic ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        flush_i = 0; it_start_i = 0; retire_i = 0; cond_valid_i = 0;
        flag_we_i = 0; it_base_i = 0; it_mask_i = 0; cond_i = 0; flag_data_i = 0;
    endtask

    task automatic load_flags(logic [3:0] f);
        @(negedge clk);
        idle_inputs();
        retire_i = 1; flag_we_i = 1; flag_data_i = f;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        #(20ns * 200000);
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #2;
        // R11 reset state
        chk(flags_o == 4'h0, "R11 flags", flags_o, 0);
        chk(it_active_o == 1'b0, "R11 active", it_active_o, 0);
        chk(exec_o == 1'b1, "R3 no field", exec_o, 1);

        // R1 R2 R3: every code against every flag value
        for (int f = 0; f < 16; f++) begin
            load_flags(f[3:0]);
            #2;
            chk(flags_o == f[3:0], "R4 load", flags_o, f);
            for (int c = 0; c < 16; c++) begin
                cond_valid_i = 1; cond_i = c[3:0]; retire_i = 1;
                #1;
                chk(exec_o == ref_pass(c[3:0], f[3:0]), "R1 cond", exec_o, ref_pass(c[3:0], f[3:0]));
                cond_valid_i = 0;
                #1;
                chk(exec_o == 1'b1, "R3 no field", exec_o, 1);
            end
            retire_i = 0;
        end

        // R4: squashed update ignored, executed update loaded
        load_flags(4'h0);
        @(negedge clk);
        retire_i = 1; cond_valid_i = 1; cond_i = 4'h0; flag_we_i = 1; flag_data_i = 4'hF;
        #1 chk(exec_o == 1'b0, "R4 squash", exec_o, 0);
        @(negedge clk);
        idle_inputs();
        #1 chk(flags_o == 4'h0, "R4 squashed write", flags_o, 0);
        flag_we_i = 1; flag_data_i = 4'hA; // no retire
        @(negedge clk);
        idle_inputs();
        #1 chk(flags_o == 4'h0, "R4 no retire", flags_o, 0);
        retire_i = 1; cond_valid_i = 1; cond_i = 4'h1; flag_we_i = 1; flag_data_i = 4'hA;
        @(negedge clk);
        idle_inputs();
        #1 chk(flags_o == 4'hA, "R4 write", flags_o, 4'hA);

        // R5 R6 R7 R8 R10: sweep masks and base codes
        for (int m = 1; m < 16; m++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] fl;
                int len;
                fl = 4'((m * 5 + b * 3) & 15);
                len = run_len(m[3:0]);
                load_flags(fl);
                it_start_i = 1; it_base_i = b[3:0]; it_mask_i = m[3:0];
                @(negedge clk);
                idle_inputs();
                for (int k = 0; k < len; k++) begin
                    logic [3:0] ec;
                    logic inv;
                    inv = (k == 0) ? 1'b0 : m[4-k];
                    ec = b[3:0] ^ {3'b000, inv};
                    retire_i = 1; cond_valid_i = 1; cond_i = 4'((k * 7 + 3) & 15);
                    #2;
                    chk(it_active_o == 1'b1, "R10 active in run", it_active_o, 1);
                    chk(exec_o == ref_pass(ec, fl), "R7 R8 slot cond", exec_o, ref_pass(ec, fl));
                    @(negedge clk);
                    idle_inputs();
                end
                #2;
                chk(it_active_o == 1'b0, "R6 run length", it_active_o, 0);
            end
        end

        // R6: zero mask ignored
        load_flags(4'h0);
        it_start_i = 1; it_base_i = 4'h0; it_mask_i = 4'h0;
        @(negedge clk);
        idle_inputs();
        retire_i = 1; cond_valid_i = 1; cond_i = 4'h1;
        #2 chk(it_active_o == 1'b0, "R6 zero mask", it_active_o, 0);
        chk(exec_o == 1'b1, "R6 zero mask exec", exec_o, 1);
        @(negedge clk);
        idle_inputs();

        // R9: flush mid run
        it_start_i = 1; it_base_i = 4'h0; it_mask_i = 4'h1;
        @(negedge clk);
        idle_inputs();
        retire_i = 1;
        @(negedge clk);
        idle_inputs();
        flush_i = 1;
        @(negedge clk);
        idle_inputs();
        #2 chk(it_active_o == 1'b0, "R9 flush", it_active_o, 0);
        chk(exec_o == 1'b1, "R9 after flush exec", exec_o, 1);

        // R9: flush beats start
        flush_i = 1; it_start_i = 1; it_mask_i = 4'h8;
        @(negedge clk);
        idle_inputs();
        #2 chk(it_active_o == 1'b0, "R9 flush over start", it_active_o, 0);

        // R9: start with retire keeps full length (one slot)
        it_start_i = 1; it_base_i = 4'h0; it_mask_i = 4'h8; retire_i = 1;
        @(negedge clk);
        idle_inputs();
        #2 chk(it_active_o == 1'b1, "R9 start with retire", it_active_o, 1);
        chk(exec_o == 1'b0, "R9 slot uses EQ", exec_o, 0);
        retire_i = 1;
        @(negedge clk);
        idle_inputs();
        #2 chk(it_active_o == 1'b0, "R9 run done", it_active_o, 0);

        // R5: squashed slots still advance
        it_start_i = 1; it_base_i = 4'h0; it_mask_i = 4'h4;
        @(negedge clk);
        idle_inputs();
        retire_i = 1; flag_we_i = 1; flag_data_i = 4'hF;
        #1 chk(exec_o == 1'b0, "R5 squash slot", exec_o, 0);
        @(negedge clk);
        idle_inputs();
        #1 chk(flags_o == 4'h0, "R4 squashed in run", flags_o, 0);
        retire_i = 1;
        #1 chk(exec_o == 1'b0, "R5 second slot", exec_o, 0);
        @(negedge clk);
        idle_inputs();
        #2 chk(it_active_o == 1'b0, "R5 advanced", it_active_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule